// File: doc/BRIEF.md
# Subtract-Compare Unit with Flags

This combinational block takes two unsigned or two's-complement operands of a configurable width and produces their difference. It also produces a set of flags describing how the two operands relate. The subtraction adds A to the bitwise inverse of B, with the adder's carry-in tied high. This is the invert-and-increment form of negating B.

The adder is split into fixed-width groups. Each group resolves its internal carries by lookahead, and the carries pass from one group to the next by ripple. The unsigned ordering flags come only from two signals: the adder's carry-out and a NOR reduction of the difference bits. The block has no separate magnitude comparator.

A separate overflow flag reports whether the same difference, read as a signed value, lies outside the representable range. The same hardware serves signed and unsigned operands. The caller chooses which flags to read.

Top module: `subcmp_unit`

## Requirements
- R1: `diff_o` equals (A − B) modulo 2^W for every pair of operands. With W=8, A=0 and B=45 this gives 211 (binary 11010011).
- R2: `carry_o` is 1 exactly when A ≥ B as unsigned numbers. When B=0 the carry is 1 and `diff_o` equals A.
- R3: `zero_o` is 1 exactly when every bit of `diff_o` is 0, which happens only when A equals B. `eq_o` always carries the same value as `zero_o`.
- R4: `ge_o` equals `carry_o`, and `lt_o` is its inverse, so exactly one of the two is high.
- R5: `gt_o` is 1 exactly when the carry is 1 and the zero flag is 0, that is, when A > B unsigned.
- R6: `le_o` is 1 exactly when the carry is 0 or the zero flag is 1, that is, when A ≤ B unsigned.
- R7: `ovf_o` is 1 exactly when the signed difference of the operands lies outside −2^(W−1) to 2^(W−1)−1. It is never 1 when A and B have the same sign bit.
- R8: All outputs are functions of the current `a_i` and `b_i` only. They follow a change of the inputs with no clock and hold no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Minuend |
| b_i | input | W | Subtrahend |
| diff_o | output | W | Difference A − B, modulo 2^W |
| carry_o | output | 1 | Adder carry-out, high when there is no borrow |
| zero_o | output | 1 | NOR of all difference bits |
| eq_o | output | 1 | A equals B |
| ge_o | output | 1 | A ≥ B unsigned |
| gt_o | output | 1 | A > B unsigned |
| lt_o | output | 1 | A < B unsigned |
| le_o | output | 1 | A ≤ B unsigned |
| ovf_o | output | 1 | Signed overflow of the difference |

## Verification
The hardest cases to reach are signed overflow and the carry crossing a group boundary. Overflow needs operands of opposite sign whose distance exceeds half the range. A carry that crosses the group boundary has to travel the full lookahead chain of the lower group.

At W=4 the bench sweeps all 256 operand pairs, so every overflow case and every carry pattern is covered. A W=8 instance then exercises the two-group chain with directed operands. These include the all-ones and all-zeros extremes, the most negative minus one, and zero minus 45.

// File: rtl/subcmp_pkg.sv
package subcmp_pkg;

  // Width of one carry-lookahead group inside the subtractor.
  localparam int GRP_W = 4;

  // Flag bundle handed from the decoder to the top level.
  typedef struct packed {
    logic zero;
    logic eq;
    logic ge;
    logic gt;
    logic lt;
    logic le;
    logic ovf;
  } cmp_flags_t;

endpackage

// File: rtl/subcmp_cla_grp.sv
// One lookahead group: every internal carry is a sum of products of
// generate/propagate terms and the group carry-in, with no ripple inside.
module subcmp_cla_grp #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] x_i,
  input  logic [GW-1:0] y_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output logic          cout_o
);

  logic [GW-1:0] prop;
  logic [GW-1:0] gen;
  logic [GW:0]   cy;

  assign prop = x_i ^ y_i;
  assign gen  = x_i & y_i;

  always_comb begin
    logic run;
    logic acc;
    cy[0] = cin_i;
    for (int k = 1; k <= GW; k++) begin
      acc = 1'b0;
      run = 1'b1;
      for (int j = k - 1; j >= 0; j--) begin
        acc = acc | (run & gen[j]);
        run = run & prop[j];
      end
      cy[k] = acc | (run & cin_i);
    end
  end

  assign sum_o  = prop ^ cy[GW-1:0];
  assign cout_o = cy[GW];

endmodule

// File: rtl/subcmp_adder.sv
// Subtractor: A plus inverted B, with carry-in forced high. The groups are
// chained by ripple between them.
module subcmp_adder #(
  parameter int W  = 8,
  parameter int GW = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] diff_o,
  output logic         carry_o
);

  localparam int NG = (W + GW - 1) / GW;
  localparam int PW = NG * GW;

  logic [PW-1:0] xa;
  logic [PW-1:0] yb;
  logic [PW-1:0] sum;
  logic [NG:0]   gcy;

  assign xa     = PW'(a_i);
  assign yb     = PW'(~b_i);
  assign gcy[0] = 1'b1;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    subcmp_cla_grp #(.GW(GW)) u_grp (
      .x_i   (xa[g*GW +: GW]),
      .y_i   (yb[g*GW +: GW]),
      .cin_i (gcy[g]),
      .sum_o (sum[g*GW +: GW]),
      .cout_o(gcy[g+1])
    );
  end

  assign diff_o = sum[W-1:0];

  if (PW == W) begin : g_exact
    assign carry_o = gcy[NG];
  end else begin : g_pad
    // Padding bits are 0 on both operands, so bit W holds the carry into W.
    assign carry_o = sum[W];
  end

endmodule

// File: rtl/subcmp_flags.sv
// Flag decoder. It uses only the carry-out, the result bits and the sign
// bits; there is no magnitude comparator.
module subcmp_flags
  import subcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] diff_i,
  input  logic         carry_i,
  input  logic         a_sign_i,
  input  logic         b_sign_i,
  output cmp_flags_t   flags_o
);

  logic nz;

  assign nz = ~(|diff_i);

  always_comb begin
    flags_o.zero = nz;
    flags_o.eq   = nz;
    flags_o.ge   = carry_i;
    flags_o.lt   = ~carry_i;
    flags_o.gt   = carry_i & ~nz;
    flags_o.le   = ~carry_i | nz;
    flags_o.ovf  = (a_sign_i ^ b_sign_i) & (diff_i[W-1] ^ a_sign_i);
  end

endmodule

// File: rtl/subcmp_unit.sv
module subcmp_unit
  import subcmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] diff_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         eq_o,
  output logic         ge_o,
  output logic         gt_o,
  output logic         lt_o,
  output logic         le_o,
  output logic         ovf_o
);

  cmp_flags_t flags;

  subcmp_adder #(.W(W), .GW(GRP_W)) u_add (
    .a_i    (a_i),
    .b_i    (b_i),
    .diff_o (diff_o),
    .carry_o(carry_o)
  );

  subcmp_flags #(.W(W)) u_flg (
    .diff_i  (diff_o),
    .carry_i (carry_o),
    .a_sign_i(a_i[W-1]),
    .b_sign_i(b_i[W-1]),
    .flags_o (flags)
  );

  assign zero_o = flags.zero;
  assign eq_o   = flags.eq;
  assign ge_o   = flags.ge;
  assign gt_o   = flags.gt;
  assign lt_o   = flags.lt;
  assign le_o   = flags.le;
  assign ovf_o  = flags.ovf;

  // Cross-checks between the adder outputs, the decoder outputs and the ports.
  always_comb begin
    p_diff_wrap_r1: assert (diff_o == W'(a_i - b_i))
      else $error("diff does not match modular difference");
    p_carry_order_r2: assert (carry_o == (a_i >= b_i))
      else $error("carry disagrees with unsigned order");
    p_zero_equal_r3: assert (zero_o == (a_i == b_i))
      else $error("zero flag disagrees with operand equality");
    p_ge_lt_excl_r4: assert (ge_o ^ lt_o)
      else $error("ge and lt not mutually exclusive");
    p_gt_not_eq_r5: assert (!(gt_o && eq_o))
      else $error("gt and eq both high");
    p_le_join_r6: assert (le_o == (lt_o | eq_o))
      else $error("le is not lt or eq");
    p_no_overflow_r7: assert (!((a_i[W-1] == b_i[W-1]) && ovf_o))
      else $error("overflow with equal operand signs");
  end

endmodule

// File: tb/sim_subcmp_unit.sv
module sim_subcmp_unit;

  logic clk;
  logic rst_n;
  int   n_chk;
  int   n_err;
  bit   done;

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // u0: 4-bit, exhaustive sweep. u1: 8-bit, directed cases.
  logic [3:0] a4, b4, d4;
  logic [7:0] a8, b8, d8;
  logic c4, z4, e4, ge4, gt4, lt4, le4, o4;
  logic c8, z8, e8, ge8, gt8, lt8, le8, o8;

  subcmp_unit #(.W(4)) u0 (
    .a_i(a4), .b_i(b4), .diff_o(d4), .carry_o(c4), .zero_o(z4), .eq_o(e4),
    .ge_o(ge4), .gt_o(gt4), .lt_o(lt4), .le_o(le4), .ovf_o(o4)
  );

  subcmp_unit #(.W(8)) u1 (
    .a_i(a8), .b_i(b8), .diff_o(d8), .carry_o(c8), .zero_o(z8), .eq_o(e8),
    .ge_o(ge8), .gt_o(gt8), .lt_o(lt8), .le_o(le8), .ovf_o(o8)
  );

  typedef struct {
    bit wide;
    int a;
    int b;
  } item_t;

  item_t q[$];

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Driver: set operands after a rising edge, queue the expected item.
  task automatic drive(input bit wide, input int a, input int b);
    item_t it;
    @(posedge clk);
    if (wide) begin a8 = 8'(a); b8 = 8'(b); end
    else      begin a4 = 4'(a); b4 = 4'(b); end
    it.wide = wide; it.a = a; it.b = b;
    q.push_back(it);
  endtask

  // Monitor: compare at the falling edge against values derived from integers.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      int w, half, sa, sb, r;
      int gd, gc, gz, ge_, geq, ggt, glt, gle, gov;
      it = q.pop_front();
      w    = it.wide ? 8 : 4;
      half = 1 << (w - 1);
      sa   = (it.a >= half) ? it.a - 2 * half : it.a;
      sb   = (it.b >= half) ? it.b - 2 * half : it.b;
      r    = sa - sb;
      if (it.wide) begin
        gd = int'(d8); gc = int'(c8); gz = int'(z8); geq = int'(e8);
        ge_ = int'(ge8); ggt = int'(gt8); glt = int'(lt8); gle = int'(le8); gov = int'(o8);
      end else begin
        gd = int'(d4); gc = int'(c4); gz = int'(z4); geq = int'(e4);
        ge_ = int'(ge4); ggt = int'(gt4); glt = int'(lt4); gle = int'(le4); gov = int'(o4);
      end
      check("R1", "diff", gd, (it.a - it.b) & (2 * half - 1));
      check("R2", "carry", gc, int'(it.a >= it.b));
      check("R3", "zero", gz, int'(it.a == it.b));
      check("R3", "eq", geq, int'(it.a == it.b));
      check("R4", "ge", ge_, int'(it.a >= it.b));
      check("R4", "lt", glt, int'(it.a < it.b));
      check("R5", "gt", ggt, int'(it.a > it.b));
      check("R6", "le", gle, int'(it.a <= it.b));
      check("R7", "ovf", gov, int'(r < -half || r > half - 1));
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0;
    a4 = '0; b4 = '0; a8 = '0; b8 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset-time state with zero operands: R3, R2, R8.
    check("R3", "zero at reset", int'(z8), 1);
    check("R2", "carry at reset", int'(c8), 1);
    check("R8", "diff at reset", int'(d8), 0);
    rst_n = 1'b1;

    // Exhaustive 4-bit sweep: R1..R7.
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        drive(1'b0, a, b);

    // Directed 8-bit cases across the group boundary.
    drive(1'b1, 0, 45);     // R1: 211
    drive(1'b1, 45, 0);     // R2: B=0
    drive(1'b1, 255, 255);  // R3
    drive(1'b1, 0, 255);
    drive(1'b1, 255, 0);
    drive(1'b1, 128, 1);    // R7: most negative minus one
    drive(1'b1, 127, 255);  // R7: max minus -1
    drive(1'b1, 16, 1);     // borrow across groups
    drive(1'b1, 3, 1);
    drive(1'b1, 200, 100);
    drive(1'b1, 100, 200);

    // R8: same operands again after other traffic give the same result.
    drive(1'b1, 0, 45);
    @(posedge clk);
    @(negedge clk);
    check("R8", "diff 0-45 repeat", int'(d8), 211);
    check("R1", "diff 0-45 bits", int'(d8), 8'b11010011);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule